// File: doc/BRIEF.md
# Serial Byte Transmitter with Line-Driver Enable

This block turns bytes offered on a valid/ready input into asynchronous serial frames on a single output line. It honours an active-low clear-to-send input from the far end, and it raises a transmit-active output that can switch a half-duplex line driver on and off. The bit time is a number of system clocks taken from a divisor input, so one design covers slow rates such as 300 baud and fast rates up to 3 Mbaud.

The transmit-active output switches on one bit time before the start bit and switches off one bit time after the stop bit. This gives the line driver time to settle in both directions. When the next byte is offered during that trailing bit time, it follows without a second lead-in and the driver stays enabled. Software or an upstream FIFO only has to present bytes and watch the ready output.

Top module: `uart_txde`

## Requirements
- R1: After reset the line is high (mark), transmit-active is low and, with clear-to-send asserted (low), ready is high; whenever transmit-active is low the line is high.
- R2: Each frame is one low start bit, then 8 data bits least significant bit first, then one high stop bit.
- R3: Every bit, and the lead and trail windows, last exactly `divisor` clock cycles; a divisor of 0 acts as 1.
- R4: Transmit-active rises on the clock edge that accepts a byte from idle, and the line stays high for exactly one bit time before the start bit.
- R5: After the stop bit, transmit-active stays high for exactly one bit time, then falls, with the line held high throughout.
- R6: A byte accepted during that trailing bit time begins its start bit on the accepting edge, with no lead window, and transmit-active does not drop between the frames.
- R7: Clear-to-send passes through two synchronising flops. While its synchronised value is high, ready is low, no byte is taken and no frame starts. A byte waiting while clear-to-send falls is accepted on the third rising edge after the fall.
- R8: Ready goes low on the accepting edge and stays low until the stop bit ends. It is high again during the trailing bit time.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Bit time in clock cycles; change only while transmit-active is low |
| inData | input | 8 | Byte to send |
| inValid | input | 1 | inData holds a byte to send |
| inReady | output | 1 | Byte is taken on a rising edge where inValid and inReady are both high |
| ctsN | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| txLine | output | 1 | Serial output, idles high |
| txActive | output | 1 | Line-driver enable, high from lead window through trail window |

## Verification
Taking the accepting edge as k and the divisor as D: transmit-active is due at the first falling edge after k; the start bit begins at edge k+D; data bit i begins at k+(2+i)·D; the stop bit ends and ready returns at k+11·D; transmit-active falls at k+12·D. A back-to-back byte drives the line low right after its own accepting edge. A byte held during a clear-to-send fall is accepted three edges after the fall. The bench samples outputs on falling edges and counts those edges from the accepting edge, so each check lands inside the cycle where the result is due. A monitor locates each start bit, samples the first falling edge of every later bit, and compares the byte with the queue that the driver fills.

// File: rtl/uart_txde_pkg.sv
package uart_txde_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_TRAIL
  } txState_t;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_START,
    LINE_DATA
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t lineSel;
  } dpStrobe_t;

endpackage

// File: rtl/uart_txde_dp.sv
module uart_txde_dp
  import uart_txde_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  dpStrobe_t         strobe,
  output logic              txLine
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= inData;
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_START: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      default:    txLine = 1'b1;
    endcase
  end

  // R2: a byte is never loaded in the same cycle a data bit is shifted out
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shift));

endmodule

// File: rtl/uart_txde_ctrl.sv
module uart_txde_ctrl
  import uart_txde_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             inValid,
  input  logic             ctsN,
  output logic             inReady,
  output logic             txActive,
  output dpStrobe_t        strobe
);

  localparam int CW    = DIV_W + 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  txState_t         state, stateNext;
  logic [DIV_W-1:0] cnt;
  logic [CW-1:0]    cntNext;
  logic [IDX_W-1:0] bitIdx;
  logic             ctsMeta, ctsSync;
  logic             tick, accept, windowOpen;

  // two-flop synchroniser, resets to "not clear"
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
    end else begin
      ctsMeta <= ctsN;
      ctsSync <= ctsMeta;
    end
  end

  assign cntNext    = {1'b0, cnt} + CW'(1);
  assign tick       = cntNext >= {1'b0, divisor};
  assign windowOpen = (state == ST_IDLE) || (state == ST_TRAIL);
  assign inReady    = windowOpen && !ctsSync;
  assign accept     = inValid && inReady;
  assign txActive   = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (accept) stateNext = ST_LEAD;
      ST_LEAD:  if (tick) stateNext = ST_START;
      ST_START: if (tick) stateNext = ST_DATA;
      ST_DATA:  if (tick && bitIdx == LAST_IDX) stateNext = ST_STOP;
      ST_STOP:  if (tick) stateNext = ST_TRAIL;
      ST_TRAIL: begin
        if (accept)    stateNext = ST_START;
        else if (tick) stateNext = ST_IDLE;
      end
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state || tick || state == ST_IDLE) cnt <= '0;
      else cnt <= cnt + DIV_W'(1);
      if (state != ST_DATA) bitIdx <= '0;
      else if (tick)        bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  always_comb begin
    strobe.load  = accept;
    strobe.shift = (state == ST_DATA) && tick;
    case (state)
      ST_START: strobe.lineSel = LINE_START;
      ST_DATA:  strobe.lineSel = LINE_DATA;
      default:  strobe.lineSel = LINE_MARK;
    endcase
  end

  // R8: ready drops right after a byte is taken
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7: a byte is only taken when the pin was low two edges earlier
  assert_cts_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ($past(ctsN, 2) == 1'b0));

  // R4: driver enable is on after any acceptance
  assert_active_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> txActive);

endmodule

// File: rtl/uart_txde.sv
module uart_txde
  import uart_txde_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              ctsN,
  output logic              txLine,
  output logic              txActive
);

  dpStrobe_t strobe;

  uart_txde_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divisor  (divisor),
    .inValid  (inValid),
    .ctsN     (ctsN),
    .inReady  (inReady),
    .txActive (txActive),
    .strobe   (strobe)
  );

  uart_txde_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .inData (inData),
    .strobe (strobe),
    .txLine (txLine)
  );

  // R1: the line rests at mark whenever the driver is off
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> txLine);

  // R4: the enable rises over a mark line, never directly into a start bit
  assert_lead_mark_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> txLine);

endmodule

// File: tb/uart_txde_tb.sv
module uart_txde_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] divisor;
  logic [7:0]  inData;
  logic        inValid;
  logic        inReady;
  logic        ctsN;
  logic        txLine;
  logic        txActive;

  int checks = 0;
  int errors = 0;
  int bitLen = 4;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  uart_txde u_dut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .inData(inData),
    .inValid(inValid), .inReady(inReady), .ctsN(ctsN),
    .txLine(txLine), .txActive(txActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: called at a falling edge; waits for ready, hands over one byte
  task automatic sendByte(input logic [7:0] b);
    while (!inReady) @(negedge clk);
    expQ.push_back(b);
    inData  = b;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setDiv(input int d);
    divisor = 16'(d);
    bitLen  = (d == 0) ? 1 : d;
  endtask

  // monitor: find start bit, sample first falling edge of each later bit
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && txLine === 1'b0) begin
        logic [7:0] got;
        logic [7:0] exp;
        check(txActive === 1'b1, "R6 enable during start bit", int'(txActive), 1);
        for (int i = 0; i < 8; i++) begin
          repeat (bitLen) @(negedge clk);
          got[i] = txLine;
        end
        repeat (bitLen) @(negedge clk);
        check(txLine === 1'b1, "R2 stop bit", int'(txLine), 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected frame", int'(got), -1);
        end else begin
          exp = expQ.pop_front();
          check(got === exp, "R2 data bits LSB first", int'(got), int'(exp));
        end
      end
    end
  end

  // full timing of one frame sent from idle (R3, R4, R5, R8)
  task automatic frameTiming(input logic [7:0] b, input string tag);
    int n;
    sendByte(b);
    check(txActive === 1'b1, {"R4 enable after accept ", tag}, int'(txActive), 1);
    check(inReady === 1'b0, {"R8 ready low after accept ", tag}, int'(inReady), 0);
    n = 0;
    while (txLine === 1'b1) begin
      n++;
      @(negedge clk);
    end
    check(n == bitLen, {"R3 R4 lead window length ", tag}, n, bitLen);
    repeat (10 * bitLen - 1) @(negedge clk);
    check(inReady === 1'b0, {"R8 ready low in stop bit ", tag}, int'(inReady), 0);
    @(negedge clk);
    check(inReady === 1'b1, {"R8 ready back in trail ", tag}, int'(inReady), 1);
    check(txActive === 1'b1 && txLine === 1'b1, {"R5 trail start ", tag}, int'(txActive), 1);
    repeat (bitLen - 1) @(negedge clk);
    check(txActive === 1'b1, {"R5 trail last cycle ", tag}, int'(txActive), 1);
    @(negedge clk);
    check(txActive === 1'b0, {"R5 enable falls ", tag}, int'(txActive), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int n;
    rstN = 1'b0; ctsN = 1'b0; inValid = 1'b0; inData = 8'h00;
    setDiv(4);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R1 reset line", int'(txLine), 1);
    check(txActive === 1'b0, "R1 reset enable", int'(txActive), 0);
    check(inReady === 1'b1, "R1 reset ready", int'(inReady), 1);

    frameTiming(8'hA5, "div4");
    setDiv(7);
    frameTiming(8'h3C, "div7");
    setDiv(1);
    frameTiming(8'h81, "div1");
    setDiv(0);
    frameTiming(8'h7E, "div0");

    // R6: back-to-back during the trailing window
    setDiv(5);
    repeat (2) @(negedge clk);
    sendByte(8'h12);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    check(txActive === 1'b1, "R6 in trail before second byte", int'(txActive), 1);
    sendByte(8'h34);
    check(txLine === 1'b0, "R6 start bit right after accept", int'(txLine), 0);
    check(txActive === 1'b1, "R6 enable kept high", int'(txActive), 1);
    do @(negedge clk); while (txActive);

    // R7: clear-to-send gating and its synchroniser latency
    setDiv(3);
    ctsN = 1'b1;
    repeat (3) @(negedge clk);
    check(inReady === 1'b0, "R7 ready low while not clear", int'(inReady), 0);
    inData = 8'hC3;
    inValid = 1'b1;
    n = 0;
    repeat (10) begin
      @(negedge clk);
      if (txActive !== 1'b0 || txLine !== 1'b1 || inReady !== 1'b0) n++;
    end
    check(n == 0, "R7 no frame while not clear", n, 0);
    expQ.push_back(8'hC3);
    ctsN = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!txActive);
    inValid = 1'b0;
    check(n == 3, "R7 accept latency after clear", n, 3);
    do @(negedge clk); while (txActive);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R2 all frames seen", expQ.size(), 0);
    finishRun();
  end

endmodule